// File: doc/BRIEF.md
# I2C Target Front End

This block is the serial-bus front end of a small peripheral that answers as a target on a two-wire I2C bus. It runs entirely on the system clock. The clock and data lines pass through a synchroniser, and their edges are found by comparing successive samples. The front end recognises bus start and stop conditions. It compares the incoming 7-bit target address against a fixed upper field plus three strap pins, and it answers with an acknowledge when the address is its own. It controls the data line only as an open-drain pull-down enable.

Each completed write byte is handed to the register logic on a one-cycle valid strobe together with the byte. For reads, the block raises a one-cycle request, takes the byte the register logic presents, and shifts it out most significant bit first. When the master answers a byte with a not-acknowledge, the read burst ends and the block stays silent until a stop condition. A repeated start in the middle of a transaction begins a new address phase without a stop first. The system clock must run at least eight times faster than SCL.

Top module: `i2c_target_front`

## Requirements
- R1: Nothing on the bus is acted upon until a START (SDA falling while SCL is high) has been seen: after reset, a full address byte and a data byte clocked without a START get no acknowledge and no write strobe.
- R2: The target address is the 7 bits received MSB first after START. It matches when its upper four bits equal binary 0100 and its lower three bits equal strap_i[2:0]. The eighth bit selects direction: 1 is a read and 0 is a write. A matching address is acknowledged.
- R3: An acknowledge drives sda_drive_o high (the line pulled low) before the ninth SCL rise and holds it for the whole high phase of that ninth clock.
- R4: In a write transaction every data byte is acknowledged on its ninth clock. After the eighth bit of a byte, wr_valid_o pulses for exactly one cycle and wr_data_o carries the byte, with the first received bit as bit 7.
- R5: In a read transaction, rd_req_o pulses for one cycle during the address acknowledge and again after each master acknowledge. rd_data_i is taken on the clock edge that ends the rd_req_o cycle and is sent MSB first. SDA is released for the ninth clock so that the master can acknowledge.
- R6: A master not-acknowledge during a read ends the burst. The block then releases SDA and issues no further requests, and it ignores all bus activity, including a START, until a STOP.
- R7: A STOP (SDA rising while SCL is high) ends any transaction and releases SDA. Bytes clocked after it without a new START get no acknowledge and no write strobe.
- R8: A START during a transaction (a repeated START) restarts address reception without a STOP first, and the new direction bit takes effect.
- R9: On a non-matching address the block leaves SDA released for the ninth clock and for the following byte, and it produces no write strobe until the next START.
- R10: sda_drive_o changes only while SCL is low. It does not change during an SCL high phase except to release at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Hardwired low address bits |
| sda_drive_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_data_o | output | 8 | Received write byte |
| rd_req_o | output | 1 | One-cycle request for the next read byte |
| rd_data_i | input | 8 | Read byte, taken at the end of the request cycle |

## Verification
The hardest state to reach from the ports is the silent state after a master not-acknowledge. Reaching it needs a matched read address, at least one acknowledged byte and then a declined byte. The bench builds exactly that sequence. It then clocks a further byte, and issues a START carrying the block's own address, to show that neither is answered and no request escapes. A STOP then shows that the block recovers. The address sweep runs every strap setting against the matching address and against near misses in both fields, so a stuck or swapped strap or prefix bit makes an expected acknowledge disappear or an unexpected one appear.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_WAIT,
      ST_ACK,
      ST_WR,
      ST_RD,
      ST_RD_ACK,
      ST_RD_LOAD,
      ST_HALT
   } tgt_state_t;

   typedef struct packed {
      logic scl;
      logic sda;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_evt_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '1;
            else        chain[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '1;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
   import i2c_tgt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      evt.scl      = scl_s;
      evt.sda      = sda_s;
      evt.scl_rise = scl_s & ~scl_q;
      evt.scl_fall = ~scl_s & scl_q;
      evt.start    = scl_s & scl_q & sda_q & ~sda_s;
      evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
   end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter int                  PREFIX_W    = 4,
   parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 4'b0100,
   parameter int                  STRAP_W     = 3,
   parameter int                  DATA_W      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  bus_evt_t           evt,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               sda_drive_o,
   output logic               wr_valid_o,
   output logic [DATA_W-1:0]  wr_data_o,
   output logic               rd_req_o,
   input  logic [DATA_W-1:0]  rd_data_i
);

   localparam int ADDR_W = PREFIX_W + STRAP_W;
   localparam int CNT_W  = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(DATA_W);

   tgt_state_t        state;
   logic [DATA_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              rw;
   logic              addr_hit;

   assign addr_hit = (sh[ADDR_W-1:0] == {ADDR_PREFIX, strap_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         sh          <= '0;
         cnt         <= '0;
         rw          <= 1'b0;
         sda_drive_o <= 1'b0;
         wr_valid_o  <= 1'b0;
         wr_data_o   <= '0;
         rd_req_o    <= 1'b0;
      end else begin
         wr_valid_o <= 1'b0;
         rd_req_o   <= 1'b0;
         if (evt.stop) begin
            state       <= ST_IDLE;
            sda_drive_o <= 1'b0;
         end else if (evt.start && state != ST_HALT) begin
            state       <= ST_ADDR;
            cnt         <= '0;
            sda_drive_o <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: if (evt.scl_rise) begin
                  if (cnt == LAST_BIT) begin
                     rw    <= evt.sda;
                     cnt   <= '0;
                     state <= addr_hit ? ST_ACK_WAIT : ST_IDLE;
                  end else begin
                     sh  <= {sh[DATA_W-2:0], evt.sda};
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_ACK_WAIT: if (evt.scl_fall) begin
                  sda_drive_o <= 1'b1;
                  rd_req_o    <= rw;
                  state       <= ST_ACK;
               end
               ST_ACK: if (evt.scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     sda_drive_o <= ~sh[DATA_W-1];
                     state       <= ST_RD;
                  end else begin
                     sda_drive_o <= 1'b0;
                     state       <= ST_WR;
                  end
               end
               ST_WR: if (evt.scl_rise) begin
                  sh <= {sh[DATA_W-2:0], evt.sda};
                  if (cnt == LAST_BIT) begin
                     wr_data_o  <= {sh[DATA_W-2:0], evt.sda};
                     wr_valid_o <= 1'b1;
                     state      <= ST_ACK_WAIT;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_RD: begin
                  if (evt.scl_rise) cnt <= cnt + 1'b1;
                  if (evt.scl_fall) begin
                     if (cnt == FULL) begin
                        sda_drive_o <= 1'b0;
                        state       <= ST_RD_ACK;
                     end else begin
                        sh          <= sh << 1;
                        sda_drive_o <= ~sh[DATA_W-2];
                     end
                  end
               end
               ST_RD_ACK: if (evt.scl_rise) begin
                  if (!evt.sda) begin
                     rd_req_o <= 1'b1;
                     state    <= ST_RD_LOAD;
                  end else begin
                     state    <= ST_HALT;
                  end
               end
               ST_RD_LOAD: if (evt.scl_fall) begin
                  sda_drive_o <= ~sh[DATA_W-1];
                  cnt         <= '0;
                  state       <= ST_RD;
               end
               default: ;
            endcase
         end
         if (rd_req_o) sh <= rd_data_i;
      end
   end

   logic fall_w;
   logic scl_w;
   logic start_w;
   logic stop_w;
   assign fall_w  = evt.scl_fall;
   assign scl_w   = evt.scl;
   assign start_w = evt.start;
   assign stop_w  = evt.stop;

   // R3
   ack_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_o) |-> $past(fall_w));
   // R10
   drive_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(scl_w) && !$past(start_w) && !$past(stop_w)) |-> $stable(sda_drive_o));
   // R7
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_w |=> !sda_drive_o);
   // R8
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> !sda_drive_o);
   // R4
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |=> !wr_valid_o);
   // R5
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o);

endmodule

// File: rtl/i2c_target_front.sv
module i2c_target_front
   import i2c_tgt_pkg::*;
#(
   parameter int                  SYNC_STAGES = 2,
   parameter int                  PREFIX_W    = 4,
   parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 4'b0100,
   parameter int                  STRAP_W     = 3,
   parameter int                  DATA_W      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               sda_drive_o,
   output logic               wr_valid_o,
   output logic [DATA_W-1:0]  wr_data_o,
   output logic               rd_req_o,
   input  logic [DATA_W-1:0]  rd_data_i
);

   localparam int ADDR_W = PREFIX_W + STRAP_W;

   if (ADDR_W != 7) begin : g_bad_addr_w
      $error("target address must total seven bits");
   end
   if (DATA_W != ADDR_W + 1) begin : g_bad_data_w
      $error("byte width must be address width plus direction bit");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchroniser stages are required");
   end

   logic [1:0] line_s;
   bus_evt_t   evt;

   i2c_tgt_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({scl_i, sda_i}),
      .dout (line_s)
   );

   i2c_tgt_cond i_cond (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_s(line_s[1]),
      .sda_s(line_s[0]),
      .evt  (evt)
   );

   i2c_tgt_engine #(
      .PREFIX_W   (PREFIX_W),
      .ADDR_PREFIX(ADDR_PREFIX),
      .STRAP_W    (STRAP_W),
      .DATA_W     (DATA_W)
   ) i_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .strap_i    (strap_i),
      .sda_drive_o(sda_drive_o),
      .wr_valid_o (wr_valid_o),
      .wr_data_o  (wr_data_o),
      .rd_req_o   (rd_req_o),
      .rd_data_i  (rd_data_i)
   );

endmodule

// File: tb/test_i2c_target_front.sv
module test_i2c_target_front;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 6;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'd0;
   logic [7:0] rd_data;
   logic       drive;
   logic       wr_valid;
   logic [7:0] wr_data;
   logic       rd_req;
   wire        sda_bus = sda_m & ~drive;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_target_front i_i2c_target_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_bus),
      .strap_i    (strap),
      .sda_drive_o(drive),
      .wr_valid_o (wr_valid),
      .wr_data_o  (wr_data),
      .rd_req_o   (rd_req),
      .rd_data_i  (rd_data)
   );

   int         checks = 0;
   int         fails  = 0;
   int         wr_cnt = 0;
   int         rd_idx = 0;
   int         viol   = 0;
   logic [7:0] wr_last = 8'h00;
   logic       drive_prev = 1'b0;
   logic       scl_prev   = 1'b1;

   function automatic logic [7:0] rd_pat(int k);
      return 8'h5A ^ 8'(k * 53);
   endfunction

   assign rd_data = rd_pat(rd_idx);

   always @(posedge clk) if (rd_req) rd_idx <= rd_idx + 1;

   always @(negedge clk) begin
      if (wr_valid) begin
         wr_cnt  = wr_cnt + 1;
         wr_last = wr_data;
      end
      if (rst_n && scl_m && scl_prev && drive !== drive_prev) viol = viol + 1;
      drive_prev = drive;
      scl_prev   = scl_m;
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic do_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic do_bit(input logic b, output logic r, output logic all_low);
      sda_m = b; tick(Q);
      scl_m = 1'b1;
      all_low = 1'b1;
      r = 1'b1;
      for (int i = 0; i < 2*Q; i++) begin
         tick(1);
         if (sda_bus) all_low = 1'b0;
         if (i == Q) r = sda_bus;
      end
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack, output logic held);
      logic r, l;
      for (int i = 7; i >= 0; i--) do_bit(v[i], r, l);
      do_bit(1'b1, r, l);
      ack  = !r;
      held = l;
   endtask

   task automatic recv_byte(input logic m_ack, output logic [7:0] v);
      logic r, l;
      v = 8'h00;
      for (int i = 0; i < 8; i++) begin
         do_bit(1'b1, r, l);
         v = {v[6:0], r};
      end
      do_bit(!m_ack, r, l);
   endtask

   initial begin
      logic       ack, held;
      logic [7:0] v;
      logic [6:0] addr;
      int         base, w0;
      logic [3:0] wrong [5];
      wrong[0] = 4'b0000; wrong[1] = 4'b0101; wrong[2] = 4'b1100;
      wrong[3] = 4'b0110; wrong[4] = 4'b0100;

      tick(4);
      check(drive == 1'b0, "R7", "reset sda_drive", int'(drive), 0);
      check(wr_valid == 1'b0, "R4", "reset wr_valid", int'(wr_valid), 0);
      check(rd_req == 1'b0, "R5", "reset rd_req", int'(rd_req), 0);
      rst_n = 1'b1;
      tick(4);

      // R1: no START yet
      scl_m = 1'b0; tick(Q);
      send_byte({4'b0100, strap, 1'b0}, ack, held);
      check(ack == 1'b0, "R1", "addr ack without start", int'(ack), 0);
      send_byte(8'h3C, ack, held);
      check(ack == 1'b0 && wr_cnt == 0, "R1", "data ignored without start", wr_cnt, 0);
      do_stop();

      // R2 / R3 / R9 sweep over straps and near-miss addresses
      for (int s = 0; s < 8; s++) begin
         strap = 3'(s);
         tick(2);
         for (int j = 0; j < 6; j++) begin
            logic       exp;
            logic [7:0] d;
            exp  = (j == 0);
            if (j == 0)      addr = {4'b0100, 3'(s)};
            else if (j == 5) addr = {4'b0100, 3'(s) ^ 3'b100};
            else             addr = {wrong[j-1] ^ ((j == 4) ? 4'b0001 : 4'b0000), 3'(s)};
            d  = 8'(s * 17 + j * 3 + 1);
            w0 = wr_cnt;
            do_start();
            send_byte({addr, 1'b0}, ack, held);
            check(ack == exp, "R2", "address ack", int'(ack), int'(exp));
            if (exp) check(held == 1'b1, "R3", "ack held over high phase", int'(held), 1);
            send_byte(d, ack, held);
            check(ack == exp, exp ? "R4" : "R9", "data byte ack", int'(ack), int'(exp));
            check(wr_cnt - w0 == (exp ? 1 : 0), exp ? "R4" : "R9", "write strobes", wr_cnt - w0, exp ? 1 : 0);
            if (exp) check(wr_last == d, "R4", "write data", int'(wr_last), int'(d));
            do_stop();
         end
      end

      // R4 multi-byte write with boundary values
      strap = 3'd5;
      tick(2);
      do_start();
      send_byte({4'b0100, 3'd5, 1'b0}, ack, held);
      check(ack, "R4", "write address ack", int'(ack), 1);
      for (int k = 0; k < 4; k++) begin
         logic [7:0] d;
         d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(8'h81 + k * 40);
         w0 = wr_cnt;
         send_byte(d, ack, held);
         check(ack && held, "R4", "burst byte ack", int'(ack), 1);
         check(wr_cnt == w0 + 1 && wr_last == d, "R4", "burst byte data", int'(wr_last), int'(d));
      end
      do_stop();

      // R5 / R6 read burst ended by not-acknowledge
      base = rd_idx;
      do_start();
      send_byte({4'b0100, 3'd5, 1'b1}, ack, held);
      check(ack && held, "R5", "read address ack", int'(ack), 1);
      for (int k = 0; k < 3; k++) begin
         recv_byte(k < 2, v);
         check(v == rd_pat(base + k), "R5", "read byte", int'(v), int'(rd_pat(base + k)));
      end
      check(rd_idx == base + 3, "R6", "requests after nack", rd_idx, base + 3);
      recv_byte(1'b1, v);
      check(v == 8'hFF, "R6", "bus released after nack", int'(v), 8'hFF);
      check(rd_idx == base + 3, "R6", "no request while halted", rd_idx, base + 3);
      w0 = wr_cnt;
      do_start();
      send_byte({4'b0100, 3'd5, 1'b0}, ack, held);
      check(ack == 1'b0, "R6", "start ignored while halted", int'(ack), 0);
      send_byte(8'h77, ack, held);
      check(ack == 1'b0 && wr_cnt == w0, "R6", "byte ignored while halted", wr_cnt - w0, 0);
      do_stop();
      do_start();
      send_byte({4'b0100, 3'd5, 1'b0}, ack, held);
      check(ack, "R6", "recovered after stop", int'(ack), 1);
      do_stop();

      // R7 STOP ends the transaction
      do_start();
      send_byte({4'b0100, 3'd5, 1'b0}, ack, held);
      check(ack, "R7", "address ack", int'(ack), 1);
      do_stop();
      w0 = wr_cnt;
      scl_m = 1'b0; tick(Q);
      send_byte({4'b0100, 3'd5, 1'b0}, ack, held);
      check(ack == 1'b0, "R7", "no ack after stop", int'(ack), 0);
      send_byte(8'h55, ack, held);
      check(ack == 1'b0 && wr_cnt == w0, "R7", "no strobe after stop", wr_cnt - w0, 0);
      do_stop();

      // R8 repeated START switches to read
      do_start();
      send_byte({4'b0100, 3'd5, 1'b0}, ack, held);
      send_byte(8'h9C, ack, held);
      check(ack && wr_last == 8'h9C, "R8", "byte before restart", int'(wr_last), 8'h9C);
      base = rd_idx;
      do_start();
      send_byte({4'b0100, 3'd5, 1'b1}, ack, held);
      check(ack, "R8", "read address after restart", int'(ack), 1);
      recv_byte(1'b0, v);
      check(v == rd_pat(base), "R8", "read byte after restart", int'(v), int'(rd_pat(base)));
      do_stop();

      // R10 drive stable while SCL high
      check(viol == 0, "R10", "drive changes with SCL high", viol, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule